// File: doc/BRIEF.md
# Prioritised Interrupt Request and Enable Controller

This block collects fourteen interrupt sources into a request register and masks them with an enable register. It presents the processor with a 3-bit priority level. The level is the highest level among the sources that are both requested and enabled. The enable register also holds one extra bit, a global gate. When that bit is clear, the level is forced to zero whatever is pending.

Software reaches each register through its own write port and its own read port. Every write is a set/clear write: bit 15 of the write data chooses whether the 1-bits of the data set or clear the matching register bits. All bits written as 0 keep their value. Peripherals raise request bits through single-cycle pulse inputs. Software can raise or drop any request bit. A peripheral pulse beats a software clear of the same bit in the same cycle. The level output is registered.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the enable register, the request register and the level output are all zero.
- R2: A write to the enable port with bit 15 = 1 sets every enable bit 14..0 written as 1; with bit 15 = 0 it clears them. Bits written as 0 keep their value. Writing 0xC020 sets the global gate (bit 14) and the vertical-blank enable (bit 5).
- R3: A write to the request port with bit 15 = 1 sets every request bit 13..0 written as 1; with bit 15 = 0 it clears them. Bit 14 of request write data has no effect.
- R4: A one-cycle pulse on source input i sets request bit i at the next clock edge. Other request bits are not changed by it.
- R5: When a source pulse and a software clear of the same request bit occur in the same cycle, the bit ends up set.
- R6: Bit 15 of both read ports reads 0. Bit 14 of the request read port reads 0. Read ports show the registers directly.
- R7: Source bits map to levels as follows: bit 13 (external) to 6; bits 12 (disk sync) and 11 (serial receive full) to 5; bits 10..7 (audio 3..0) to 4; bits 6 (blitter done), 5 (vertical blank) and 4 (copper) to 3; bit 3 (ports) to 2; bits 2 (software), 1 (disk block done) and 0 (serial transmit empty) to 1.
- R8: The level is the maximum mapped level over all bits whose request and enable are both 1, or 0 if there is none.
- R9: While enable bit 14 is 0, the level is 0.
- R10: The level follows the registers one clock late. A register change made at edge t shows on the level output after edge t+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse_i | input | 14 | One-cycle set pulses from the interrupt sources |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 16 | Enable write data; bit 15 selects set (1) or clear (0) |
| req_wr_i | input | 1 | Request register write strobe |
| req_wdata_i | input | 16 | Request write data; bit 15 selects set (1) or clear (0) |
| en_rdata_o | output | 16 | Enable register read value |
| req_rdata_o | output | 16 | Request register read value |
| level_o | output | 3 | Registered processor priority level |

## Verification
Directed sequences raise one source at a time, with every enable and the gate on, so that each source's own level is seen alone. A wrong entry in the mapping is then pinned to one bit. Further directed steps enable a low and a high source together, drop the gate, and meet a pulse with a software clear of the same bit. These steps tell the maximum selection, gating and pulse priority apart from plain register storage. The level is also sampled the cycle right after a register write, which catches a level that is not registered or is registered twice. A long random run then mixes set and clear writes to both ports with sparse source pulses. Every cycle it compares both read ports and the level against a model built from the requirements, covering write patterns the directed steps never reach.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned NUM_SRC    = 14;
    localparam int unsigned REG_W      = 16;
    localparam int unsigned LVL_W      = 3;
    localparam int unsigned SETCLR_BIT = 15;
    localparam int unsigned GATE_BIT   = 14;
    localparam int unsigned EN_W       = NUM_SRC + 1;

    // fixed many-to-one map of source index onto processor level (R7)
    function automatic logic [LVL_W-1:0] src_level(input int unsigned idx);
        if (idx >= 13)      return LVL_W'(6);
        else if (idx >= 11) return LVL_W'(5);
        else if (idx >= 7)  return LVL_W'(4);
        else if (idx >= 4)  return LVL_W'(3);
        else if (idx == 3)  return LVL_W'(2);
        else                return LVL_W'(1);
    endfunction

endpackage

// File: rtl/irqc_setclr_reg.sv
module irqc_setclr_reg #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic         set_not_clr_i,
    input  logic [W-1:0] wr_bits_i,
    input  logic [W-1:0] hw_set_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] bits;
    } reg_state_t;

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            if (set_not_clr_i) state_d.bits = state_q.bits | wr_bits_i;
            else               state_d.bits = state_q.bits & ~wr_bits_i;
        end
        // hardware set applied last so it wins over a clear
        state_d.bits = state_d.bits | hw_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign q_o = state_q.bits;

    assert_set_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && set_not_clr_i) |=> ((q_o & $past(wr_bits_i)) == $past(wr_bits_i)));

    assert_clear_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !set_not_clr_i) |=> ((q_o & $past(wr_bits_i & ~hw_set_i)) == '0));

    assert_pulse_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set_i) |=> ((q_o & $past(hw_set_i)) == $past(hw_set_i)));

    assert_untouched_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q_o & ~$past(hw_set_i | (wr_i ? wr_bits_i : '0)))
                  == ($past(q_o) & ~$past(hw_set_i | (wr_i ? wr_bits_i : '0)))));

endmodule

// File: rtl/irqc_level_enc.sv
module irqc_level_enc
    import irqc_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic [N-1:0]     pend_i,
    output logic [LVL_W-1:0] level_o
);

    logic [LVL_W-1:0] cand [N];

    for (genvar i = 0; i < N; i++) begin : g_cand
        assign cand[i] = pend_i[i] ? src_level(i) : '0;
    end

    always_comb begin
        level_o = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] > level_o) level_o = cand[i];
        end
    end

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse_i,
    input  logic               en_wr_i,
    input  logic [REG_W-1:0]   en_wdata_i,
    input  logic               req_wr_i,
    input  logic [REG_W-1:0]   req_wdata_i,
    output logic [REG_W-1:0]   en_rdata_o,
    output logic [REG_W-1:0]   req_rdata_o,
    output logic [LVL_W-1:0]   level_o
);

    logic [EN_W-1:0]    en_q;
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] pend;
    logic [LVL_W-1:0]   level_comb;

    typedef struct packed {
        logic [LVL_W-1:0] level;
    } top_state_t;

    top_state_t state_d, state_q;

    irqc_setclr_reg #(.W(EN_W)) u_en_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (en_wr_i),
        .set_not_clr_i(en_wdata_i[SETCLR_BIT]),
        .wr_bits_i    (en_wdata_i[EN_W-1:0]),
        .hw_set_i     ('0),
        .q_o          (en_q)
    );

    irqc_setclr_reg #(.W(NUM_SRC)) u_req_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (req_wr_i),
        .set_not_clr_i(req_wdata_i[SETCLR_BIT]),
        .wr_bits_i    (req_wdata_i[NUM_SRC-1:0]),
        .hw_set_i     (src_pulse_i),
        .q_o          (req_q)
    );

    assign pend = req_q & en_q[NUM_SRC-1:0] & {NUM_SRC{en_q[GATE_BIT]}};

    irqc_level_enc #(.N(NUM_SRC)) u_enc (
        .pend_i (pend),
        .level_o(level_comb)
    );

    always_comb begin
        state_d       = state_q;
        state_d.level = level_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign level_o     = state_q.level;
    assign en_rdata_o  = REG_W'(en_q);
    assign req_rdata_o = REG_W'(req_q);

    assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[GATE_BIT] |=> (level_o == '0));

    assert_top_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend[NUM_SRC-1] |=> (level_o == LVL_W'(6)));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> (level_o == '0));

    assert_level_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(pend) |=> $stable(level_o));

endmodule

// File: tb/irq_level_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_level_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] src_pulse = '0;
    logic        en_wr = 1'b0;
    logic [15:0] en_wdata = '0;
    logic        req_wr = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [15:0] en_rdata, req_rdata;
    logic [2:0]  level;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [14:0] en_m  = '0;
    logic [13:0] req_m = '0;
    logic [2:0]  lvl_m = '0;

    always #2.5 clk = ~clk;

    irq_level_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_pulse_i(src_pulse),
        .en_wr_i(en_wr), .en_wdata_i(en_wdata),
        .req_wr_i(req_wr), .req_wdata_i(req_wdata),
        .en_rdata_o(en_rdata), .req_rdata_o(req_rdata), .level_o(level)
    );

    function automatic logic [2:0] map_lvl(input int i);
        if (i == 13) return 3'd6;
        if (i == 12 || i == 11) return 3'd5;
        if (i >= 7 && i <= 10) return 3'd4;
        if (i >= 4 && i <= 6) return 3'd3;
        if (i == 3) return 3'd2;
        return 3'd1;
    endfunction

    function automatic logic [2:0] model_lvl(input logic [13:0] rq, input logic [14:0] en);
        logic [2:0] m = 3'd0;
        if (!en[14]) return 3'd0;
        for (int i = 0; i < 14; i++)
            if (rq[i] && en[i] && map_lvl(i) > m) m = map_lvl(i);
        return m;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
        end
    endtask

    // inputs already driven at a negedge; advance one edge, update model, compare at next negedge
    task automatic step(input string tag);
        logic [2:0] lvl_n;
        lvl_n = model_lvl(req_m, en_m);
        if (en_wr)
            en_m = en_wdata[15] ? (en_m | en_wdata[14:0]) : (en_m & ~en_wdata[14:0]);
        if (req_wr)
            req_m = req_wdata[15] ? (req_m | req_wdata[13:0]) : (req_m & ~req_wdata[13:0]);
        req_m = req_m | src_pulse;
        @(posedge clk);
        lvl_m = lvl_n;
        @(negedge clk);
        chk({tag, " en"},  en_rdata,  {1'b0, en_m});
        chk({tag, " req"}, req_rdata, {2'b00, req_m});
        chk({tag, " lvl"}, {13'd0, level}, {13'd0, lvl_m});
        en_wr = 1'b0; req_wr = 1'b0; src_pulse = '0;
    endtask

    task automatic wr_en(input logic [15:0] d);
        en_wr = 1'b1; en_wdata = d;
    endtask

    task automatic wr_req(input logic [15:0] d);
        req_wr = 1'b1; req_wdata = d;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset en",  en_rdata, 16'h0000);
        chk("R1 reset req", req_rdata, 16'h0000);
        chk("R1 reset lvl", {13'd0, level}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R6: request write with all bits set, bit 14 ignored and reads 0
        wr_req(16'hFFFF); step("R3");
        chk("R6 req bit14/15", req_rdata, 16'h3FFF);
        chk("R9 gate off lvl", {13'd0, level}, 16'h0000);

        // R2: 0xC020 sets gate and vertical blank enable
        wr_en(16'hC020); step("R2");
        chk("R2 en after C020", en_rdata, 16'h4020);
        chk("R10 level not yet", {13'd0, level}, 16'h0000);
        step("R10");
        chk("R7 vblank lvl", {13'd0, level}, 16'h0003);

        // R8: high source enabled too -> max
        wr_en(16'h8001); step("R8");
        wr_en(16'hA000); step("R8");
        step("R8");
        chk("R8 max lvl", {13'd0, level}, 16'h0006);

        // R9: gate cleared -> zero
        wr_en(16'h4000); step("R9");
        step("R9");
        chk("R9 gated lvl", {13'd0, level}, 16'h0000);
        chk("R2 clear keeps others", en_rdata, 16'h2021);

        // R4/R5: clear all requests while pulsing bit 5
        wr_en(16'hFFFF); wr_req(16'h3FFF); src_pulse = 14'h0020; step("R5");
        chk("R5 pulse beats clear", req_rdata, 16'h0020);
        src_pulse = 14'h0001; step("R4");
        chk("R4 pulse sets bit0", req_rdata, 16'h0021);

        // R7: every source alone
        for (int i = 0; i < 14; i++) begin
            wr_req(16'h3FFF); src_pulse = 14'(1) << i; step("R7");
            step("R7");
            chk($sformatf("R7 src %0d lvl", i), {13'd0, level}, {13'd0, map_lvl(i)});
        end

        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[2:0] == 3'd0) begin en_wr = 1'b1; en_wdata = 16'($urandom); end
            if (r[5:3] == 3'd0) begin req_wr = 1'b1; req_wdata = 16'($urandom); end
            if (r[7:6] == 2'd0) src_pulse = 14'($urandom) & 14'($urandom) & 14'($urandom);
            step("R8 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule